// File: doc/BRIEF.md
# Non-Posted Read Completion Tracker

This block keeps account of non-posted read requests that a local requester sends out over a serial link and waits for their completions to return. When a request is issued the block hands back a tag naming a free tracking slot; the slot records how many parts the request was split into (each part returns its own completion carrying the same tag) and starts a down-counter loaded from a programmable timeout value.

Returning completions carry a status code plus a poisoned-data flag and an end-to-end CRC failure flag. Error conditions from the parts of one request are gathered in the slot and written into the sticky error status only when the last part has returned. A slot that runs out of time is freed and logs a timeout. Any completion aimed at a slot that is not in use (for example one arriving after its slot timed out) is logged as unexpected. Status bits are cleared by writing ones, and a single interrupt line is raised while any status bit is set together with its enable.

Top module: `np_cpl_tracker`

## Requirements
- R1: After reset err_status is 0, irq is 0, req_ready is 1 and req_tag is 0.
- R2: req_ready is 1 while at least one slot is free, and req_tag names the lowest-numbered free slot; a request is taken when req_valid and req_ready are both 1 at a rising edge, and no request is taken while all slots are busy.
- R3: A slot holding a request of req_parts parts (binary, 1 to MAX_PARTS) becomes free at the edge that accepts its req_parts-th completion with that tag, and is offered again by req_tag afterwards.
- R4: With tmo_value = T at the issue edge, a slot still busy at the (T+1)-th rising edge after the issue edge is freed there and err_status bit 0 (timeout) is set; error flags gathered from its earlier parts are discarded, and bit 0 stays clear at the T-th edge.
- R5: A completion accepted at the same edge at which its slot would time out wins: no timeout is logged and the part is counted normally.
- R6: A completion whose tag names a slot that is not busy sets err_status bit 1 (unexpected).
- R7: Completion status code 3'b001 (unsupported request) sets err_status bit 2 (no success); code 3'b100 (completer abort) sets bits 2 and 3; code 3'b000 and every other code set no status bit.
- R8: A completion with cpl_poison set logs err_status bit 4; one with cpl_crc_err set logs err_status bit 5.
- R9: For a split request, errors from any part are held back and written to err_status only at the edge accepting the final part.
- R10: err_status bits are sticky; a 1 in err_clear clears that bit at the next edge, a bit that is set and cleared at the same edge stays set, and bits not named in err_clear are kept.
- R11: irq is 1 exactly when some err_status bit and the matching err_enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Issue a new request this cycle |
| req_parts | input | $clog2(MAX_PARTS+1) | Number of parts of the request, 1 to MAX_PARTS |
| req_ready | output | 1 | A free slot exists |
| req_tag | output | $clog2(NUM_ENTRIES) | Slot the next request will use |
| cpl_valid | input | 1 | A completion arrives this cycle |
| cpl_tag | input | $clog2(NUM_ENTRIES) | Slot the completion belongs to |
| cpl_status | input | 3 | Completion status code |
| cpl_poison | input | 1 | Completion carries poisoned data |
| cpl_crc_err | input | 1 | Completion failed its end-to-end CRC |
| tmo_value | input | TMO_W | Timeout loaded into a slot at issue |
| err_enable | input | 6 | Interrupt enable per status bit |
| err_clear | input | 6 | Write-one-to-clear strobe per status bit |
| err_status | output | 6 | Sticky error status |
| irq | output | 1 | Interrupt request |

## Verification
The bench issues a three-part request whose first part is poisoned and checks that nothing appears until the third part returns; a design that reported early would show bit 4 after the first completion. It times the timeout edge exactly, checking bit 0 is still clear one edge before expiry, and then drives a completion at the expiry edge itself, which a design favouring the timer would turn into a logged timeout and an unexpected completion. It fills every slot to check that a full tracker refuses a request and that a freed middle slot is the one offered next, and it clears a status bit in the same cycle that a new error sets it, which a design giving clear priority would lose.

// File: rtl/np_trk_pkg.sv
package np_trk_pkg;

   localparam int ST_W      = 6;
   localparam int ST_TMO    = 0;
   localparam int ST_UNEXP  = 1;
   localparam int ST_NOSUCC = 2;
   localparam int ST_CABORT = 3;
   localparam int ST_POISON = 4;
   localparam int ST_ECRC   = 5;

   localparam int CODE_W = 3;
   localparam logic [CODE_W-1:0] CODE_OK = 3'b000;
   localparam logic [CODE_W-1:0] CODE_UR = 3'b001;
   localparam logic [CODE_W-1:0] CODE_CA = 3'b100;

   // per-part error flags, packed in status-bit order starting at ST_NOSUCC
   typedef struct packed {
      logic ecrc;
      logic poison;
      logic cabort;
      logic nosucc;
   } part_err_t;

   localparam int PERR_W = $bits(part_err_t);

   function automatic part_err_t decode_cpl(logic [CODE_W-1:0] code,
                                            logic poison, logic ecrc);
      part_err_t e;
      e.nosucc = (code == CODE_UR) || (code == CODE_CA);
      e.cabort = (code == CODE_CA);
      e.poison = poison;
      e.ecrc   = ecrc;
      return e;
   endfunction

endpackage

// File: rtl/np_trk_alloc.sv
module np_trk_alloc #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     busy,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/np_trk_entry.sv
module np_trk_entry
   import np_trk_pkg::*;
#(
   parameter int TMO_W  = 24,
   parameter int PART_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [PART_W-1:0] alloc_parts,
   input  logic [TMO_W-1:0]  tmo_load,
   input  logic              cpl_hit,
   input  part_err_t         cpl_err,
   output logic              busy,
   output logic              done,
   output part_err_t         done_err,
   output logic              expired
);
   logic [PART_W-1:0] parts_left;
   logic [TMO_W-1:0]  cnt;
   part_err_t         acc;

   logic hit_live, last_part, cnt_zero;

   assign hit_live  = busy && cpl_hit;
   assign last_part = (parts_left == PART_W'(1));
   assign cnt_zero  = (cnt == '0);

   assign done     = hit_live && last_part;
   assign done_err = acc | cpl_err;
   assign expired  = busy && !cpl_hit && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         parts_left <= '0;
         cnt        <= '0;
         acc        <= '0;
      end else if (alloc) begin
         busy       <= 1'b1;
         parts_left <= alloc_parts;
         cnt        <= tmo_load;
         acc        <= '0;
      end else if (busy) begin
         if (hit_live) begin
            acc        <= acc | cpl_err;
            parts_left <= parts_left - PART_W'(1);
            if (last_part) begin
               busy <= 1'b0;
            end
         end else if (cnt_zero) begin
            busy <= 1'b0;
         end
         if (!cnt_zero) begin
            cnt <= cnt - TMO_W'(1);
         end
      end
   end
endmodule

// File: rtl/np_trk_status.sv
module np_trk_status #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   input  logic [W-1:0] enable,
   output logic [W-1:0] status,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
      end else begin
         status <= (status & ~clr_bits) | set_bits;
      end
   end

   assign irq = |(status & enable);
endmodule

// File: rtl/np_cpl_tracker.sv
module np_cpl_tracker
   import np_trk_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int TMO_W       = 24,
   parameter int MAX_PARTS   = 4,
   localparam int IDX_W      = $clog2(NUM_ENTRIES),
   localparam int PART_W     = $clog2(MAX_PARTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [PART_W-1:0]   req_parts,
   output logic                req_ready,
   output logic [IDX_W-1:0]    req_tag,
   input  logic                cpl_valid,
   input  logic [IDX_W-1:0]    cpl_tag,
   input  logic [CODE_W-1:0]   cpl_status,
   input  logic                cpl_poison,
   input  logic                cpl_crc_err,
   input  logic [TMO_W-1:0]    tmo_value,
   input  logic [ST_W-1:0]     err_enable,
   input  logic [ST_W-1:0]     err_clear,
   output logic [ST_W-1:0]     err_status,
   output logic                irq
);
   if (NUM_ENTRIES < 2 || (NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two of at least 2");
   end
   if (MAX_PARTS < 1) begin : g_bad_parts
      $error("MAX_PARTS must be at least 1");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("TMO_W must be at least 1");
   end

   logic [NUM_ENTRIES-1:0] busy_vec;
   logic [NUM_ENTRIES-1:0] done_vec;
   logic [NUM_ENTRIES-1:0] tmo_vec;
   part_err_t              done_err [NUM_ENTRIES];
   logic                   any_free;
   logic [IDX_W-1:0]       free_idx;
   logic                   take;
   part_err_t              cpl_err;
   part_err_t              rep_err;
   logic                   unexp;
   logic [ST_W-1:0]        set_bits;

   np_trk_alloc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_alloc (
      .busy     (busy_vec),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   assign req_ready = any_free;
   assign req_tag   = free_idx;
   assign take      = req_valid && any_free;
   assign cpl_err   = decode_cpl(cpl_status, cpl_poison, cpl_crc_err);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      np_trk_entry #(.TMO_W(TMO_W), .PART_W(PART_W)) u_entry (
         .clk         (clk),
         .rst_n       (rst_n),
         .alloc       (take && (free_idx == IDX_W'(g))),
         .alloc_parts (req_parts),
         .tmo_load    (tmo_value),
         .cpl_hit     (cpl_valid && (cpl_tag == IDX_W'(g))),
         .cpl_err     (cpl_err),
         .busy        (busy_vec[g]),
         .done        (done_vec[g]),
         .done_err    (done_err[g]),
         .expired     (tmo_vec[g])
      );
   end

   always_comb begin
      rep_err = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (done_vec[i]) begin
            rep_err = rep_err | done_err[i];
         end
      end
   end

   assign unexp = cpl_valid && !busy_vec[cpl_tag];

   always_comb begin
      set_bits                             = '0;
      set_bits[ST_TMO]                     = |tmo_vec;
      set_bits[ST_UNEXP]                   = unexp;
      set_bits[ST_NOSUCC +: PERR_W]        = rep_err;
   end

   np_trk_status #(.W(ST_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_bits),
      .clr_bits (err_clear),
      .enable   (err_enable),
      .status   (err_status),
      .irq      (irq)
   );
endmodule

// File: rtl/np_trk_checker.sv
module np_trk_checker
   import np_trk_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int MAX_PARTS   = 4,
   localparam int IDX_W      = $clog2(NUM_ENTRIES),
   localparam int PART_W     = $clog2(MAX_PARTS + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic [PART_W-1:0]      req_parts,
   input logic                   req_ready,
   input logic [IDX_W-1:0]       req_tag,
   input logic                   cpl_valid,
   input logic [IDX_W-1:0]       cpl_tag,
   input logic [ST_W-1:0]        err_enable,
   input logic [ST_W-1:0]        err_clear,
   input logic [ST_W-1:0]        err_status,
   input logic                   irq,
   input logic [NUM_ENTRIES-1:0] busy_vec
);
   AST_READY_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy_vec[req_tag]); // R2

   AST_PARTS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_parts != '0 && req_parts <= PART_W'(MAX_PARTS))); // R3

   AST_UNEXP_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !busy_vec[cpl_tag]) |=> err_status[ST_UNEXP]); // R6

   AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(err_status) & ~$past(err_clear) & ~err_status) == '0)); // R10

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (err_enable == '0) |-> !irq); // R11
endmodule

bind np_cpl_tracker np_trk_checker #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .MAX_PARTS   (MAX_PARTS)
) u_np_trk_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_parts  (req_parts),
   .req_ready  (req_ready),
   .req_tag    (req_tag),
   .cpl_valid  (cpl_valid),
   .cpl_tag    (cpl_tag),
   .err_enable (err_enable),
   .err_clear  (err_clear),
   .err_status (err_status),
   .irq        (irq),
   .busy_vec   (busy_vec)
);

// File: tb/test_np_cpl_tracker.sv
`timescale 1ns/1ps
module test_np_cpl_tracker;
   localparam int N      = 8;
   localparam int TMO_W  = 24;
   localparam int MAXP   = 4;
   localparam int IDX_W  = 3;
   localparam int PART_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [PART_W-1:0] req_parts = 3'd1;
   logic              req_ready;
   logic [IDX_W-1:0]  req_tag;
   logic              cpl_valid = 1'b0;
   logic [IDX_W-1:0]  cpl_tag = '0;
   logic [2:0]        cpl_status = 3'b000;
   logic              cpl_poison = 1'b0;
   logic              cpl_crc_err = 1'b0;
   logic [TMO_W-1:0]  tmo_value = 24'd1000;
   logic [5:0]        err_enable = 6'h00;
   logic [5:0]        err_clear = 6'h00;
   logic [5:0]        err_status;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   np_cpl_tracker #(.NUM_ENTRIES(N), .TMO_W(TMO_W), .MAX_PARTS(MAXP)) i_np_cpl_tracker (
      .clk, .rst_n, .req_valid, .req_parts, .req_ready, .req_tag,
      .cpl_valid, .cpl_tag, .cpl_status, .cpl_poison, .cpl_crc_err,
      .tmo_value, .err_enable, .err_clear, .err_status, .irq
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic issue(input logic [PART_W-1:0] parts, output logic [IDX_W-1:0] tag);
      tag       = req_tag;
      req_valid = 1'b1;
      req_parts = parts;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic complete(input logic [IDX_W-1:0] tag, input logic [2:0] code,
                           input logic poison, input logic crc);
      cpl_valid   = 1'b1;
      cpl_tag     = tag;
      cpl_status  = code;
      cpl_poison  = poison;
      cpl_crc_err = crc;
      @(negedge clk);
      cpl_valid   = 1'b0;
      cpl_poison  = 1'b0;
      cpl_crc_err = 1'b0;
      cpl_status  = 3'b000;
   endtask

   task automatic clear_all();
      err_clear = 6'h3f;
      @(negedge clk);
      err_clear = 6'h00;
   endtask

   task automatic t_reset();
      chk("R1", "err_status", 32'(err_status), 32'h0);
      chk("R1", "irq", 32'(irq), 32'h0);
      chk("R1", "req_ready", 32'(req_ready), 32'h1);
      chk("R1", "req_tag", 32'(req_tag), 32'h0);
   endtask

   task automatic t_single_ok();
      logic [IDX_W-1:0] t;
      issue(3'd1, t);
      chk("R2", "first tag", 32'(t), 32'h0);
      chk("R2", "next tag", 32'(req_tag), 32'h1);
      complete(t, 3'b000, 1'b0, 1'b0);
      chk("R3", "slot freed", 32'(req_tag), 32'h0);
      chk("R7", "clean status", 32'(err_status), 32'h0);
   endtask

   task automatic t_split_held();
      logic [IDX_W-1:0] t;
      issue(3'd3, t);
      complete(t, 3'b000, 1'b1, 1'b0);
      chk("R9", "held after part 1", 32'(err_status), 32'h0);
      complete(t, 3'b000, 1'b0, 1'b0);
      chk("R9", "held after part 2", 32'(err_status), 32'h0);
      chk("R3", "still busy", 32'(req_tag), 32'h1);
      complete(t, 3'b000, 1'b0, 1'b0);
      chk("R8", "poison after last part", 32'(err_status), 32'h10);
      chk("R3", "freed after part 3", 32'(req_tag), 32'h0);
      clear_all();
   endtask

   task automatic t_codes();
      logic [IDX_W-1:0] t;
      issue(3'd1, t);
      complete(t, 3'b001, 1'b0, 1'b0);
      chk("R7", "unsupported request", 32'(err_status), 32'h04);
      clear_all();
      issue(3'd1, t);
      complete(t, 3'b100, 1'b0, 1'b0);
      chk("R7", "completer abort", 32'(err_status), 32'h0c);
      clear_all();
      issue(3'd1, t);
      complete(t, 3'b010, 1'b0, 1'b0);
      chk("R7", "other code", 32'(err_status), 32'h00);
      issue(3'd1, t);
      complete(t, 3'b000, 1'b0, 1'b1);
      chk("R8", "crc error", 32'(err_status), 32'h20);
      clear_all();
   endtask

   task automatic t_irq_clear();
      logic [IDX_W-1:0] t;
      issue(3'd1, t);
      complete(t, 3'b100, 1'b0, 1'b0);
      chk("R11", "irq masked", 32'(irq), 32'h0);
      err_enable = 6'h10;
      #1;
      chk("R11", "irq other bit enabled", 32'(irq), 32'h0);
      err_enable = 6'h08;
      #1;
      chk("R11", "irq enabled", 32'(irq), 32'h1);
      err_clear = 6'h08;
      @(negedge clk);
      err_clear = 6'h00;
      chk("R10", "partial clear", 32'(err_status), 32'h04);
      chk("R11", "irq after clear", 32'(irq), 32'h0);
      // new unsupported request while clearing bit 2 in the same cycle
      issue(3'd1, t);
      err_clear = 6'h04;
      complete(t, 3'b001, 1'b0, 1'b0);
      err_clear = 6'h00;
      chk("R10", "set wins over clear", 32'(err_status), 32'h04);
      err_enable = 6'h00;
      clear_all();
      chk("R10", "cleared", 32'(err_status), 32'h00);
   endtask

   task automatic t_full();
      logic [IDX_W-1:0] t;
      for (int i = 0; i < N; i++) begin
         issue(3'd1, t);
         chk("R2", "fill tag", 32'(t), 32'(i));
      end
      chk("R2", "full ready", 32'(req_ready), 32'h0);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      complete(3'd5, 3'b000, 1'b0, 1'b0);
      chk("R2", "ready after free", 32'(req_ready), 32'h1);
      chk("R2", "freed middle slot", 32'(req_tag), 32'h5);
      for (int i = 0; i < N; i++) begin
         if (i != 5) complete(IDX_W'(i), 3'b000, 1'b0, 1'b0);
      end
      chk("R2", "no request taken while full", 32'(err_status), 32'h00);
      chk("R3", "all free", 32'(req_tag), 32'h0);
   endtask

   task automatic t_timeout();
      logic [IDX_W-1:0] t;
      tmo_value = 24'd4;
      issue(3'd2, t);                    // issue edge E0
      tmo_value = 24'd1000;
      complete(t, 3'b000, 1'b1, 1'b0);   // edge E1, poisoned part
      repeat (3) @(negedge clk);         // after E4
      chk("R4", "not yet expired", 32'(err_status), 32'h00);
      @(negedge clk);                    // after E5
      chk("R4", "timeout only", 32'(err_status), 32'h01);
      chk("R4", "slot freed", 32'(req_tag), 32'(t));
      complete(t, 3'b000, 1'b0, 1'b0);
      chk("R6", "late completion", 32'(err_status), 32'h03);
      clear_all();
      complete(3'd6, 3'b000, 1'b0, 1'b0);
      chk("R6", "never used slot", 32'(err_status), 32'h02);
      clear_all();
   endtask

   task automatic t_race();
      logic [IDX_W-1:0] t;
      tmo_value = 24'd4;
      issue(3'd1, t);                    // E0
      tmo_value = 24'd1000;
      repeat (4) @(negedge clk);         // after E4
      complete(t, 3'b000, 1'b0, 1'b0);   // accepted at E5
      chk("R5", "completion wins", 32'(err_status), 32'h00);
      chk("R5", "slot freed", 32'(req_tag), 32'(t));
      repeat (3) @(negedge clk);
      chk("R5", "no later timeout", 32'(err_status), 32'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_ok();
      t_split_held();
      t_codes();
      t_irq_clear();
      t_full();
      t_timeout();
      t_race();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule